// File: doc/BRIEF.md
# Dual-Rail Four-Phase Data Channel

This block is a clocked model of a delay-insensitive data link. A sending side takes an ordinary binary word through a valid/ready handshake and places it on a bus where every bit has two wires: a "true" wire and a "false" wire. Both wires low is the empty spacer. Exactly one wire high gives the bit value. A receiving side watches the bus. When every pair holds a value it decodes the word and raises an acknowledge. It lowers the acknowledge once every pair has gone back to the spacer. Only after that may the sender start the next word.

The bus leaves the block on the sender pins and comes back in on the receiver pins, so the integrating level wires the two together, with whatever delay it likes on the acknowledge. The receiver also counts every wire toggle it sees, as an activity (power) estimate. That counter saturates and can be cleared synchronously. A pair with both wires high is illegal and is flagged.

Top module: `dr_channel_top`

## Requirements
- R1: Bit i is encoded on the pair (tx_t[i], tx_f[i]): 10 means logic 1, 01 means logic 0, 00 is the spacer. The sender never drives 11 on any pair.
- R2: A word is accepted on a clock edge where in_valid and in_ready are both high. in_ready is high only when the sender is idle on spacer and tx_ack is low. The codeword is on tx_t/tx_f after that same edge.
- R3: The sender holds the codeword unchanged until it samples tx_ack high. It drives the full spacer after that edge, and it returns to idle on the first edge where tx_ack is sampled low.
- R4: One clock after every receiver pair holds exactly one high wire, with rx_ack low, rx_ack rises and out_valid pulses for one cycle. out_data then carries rx_t.
- R5: While rx_ack is high, rx_ack falls one clock after every receiver pair reads 00.
- R6: A pair reading 11 sets proto_err in the next cycle, for each cycle it is present. Such a word never counts as complete, so it raises no acknowledge.
- R7: act_count adds, one clock later, the number of rx_t/rx_f wires that changed since the previous cycle. A complete transfer therefore adds 2*WIDTH.
- R8: act_count saturates at all ones and stays there.
- R9: cnt_clr makes act_count zero on the next edge and takes priority over any increment in that cycle.
- R10: After reset the sender drives spacer and in_ready is high. rx_ack, out_valid and proto_err are low, and act_count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of the activity counter |
| in_valid | input | 1 | Sender word valid |
| in_data | input | WIDTH | Sender word |
| in_ready | output | 1 | Sender can accept a word |
| tx_t | output | WIDTH | Sender true rails |
| tx_f | output | WIDTH | Sender false rails |
| tx_ack | input | 1 | Acknowledge returning to the sender |
| rx_t | input | WIDTH | Receiver true rails |
| rx_f | input | WIDTH | Receiver false rails |
| rx_ack | output | 1 | Acknowledge raised by the receiver |
| out_valid | output | 1 | One-cycle pulse with a decoded word |
| out_data | output | WIDTH | Decoded word |
| proto_err | output | 1 | Illegal 11 pair seen in the previous cycle |
| act_count | output | CNT_W | Saturating wire-transition count |

## Verification
Accepting a word puts the codeword on the pins after the accept edge. out_valid and the rising acknowledge follow one edge later, so the bench samples them at exactly the second falling edge after it drives in_valid. proto_err and each counter change are due one edge after the wire change that causes them, and each is checked at the next falling edge. The acknowledge return path has a delay set by the bench of zero to seven cycles, so the bench waits with a bound for in_ready to come back. It then checks the spacer, the low acknowledge and the counter, all of which have settled by that edge.

// File: rtl/dr_pkg.sv
// Package: shared types of the dual-rail channel.
// Assumes: nothing beyond IEEE 1800-2017.
package dr_pkg;

    // Sender phase within one four-phase transfer.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,   // spacer on bus, waiting for a word
        TX_DATA = 2'd1,   // codeword on bus, waiting for ack high
        TX_RTZ  = 2'd2    // spacer on bus, waiting for ack low
    } tx_state_e;

endpackage

// File: rtl/dr_tx.sv
// Module: dr_tx
// Converts a single-rail word to dual-rail pairs and sequences the four
// phases. Spacer to codeword and codeword to spacer each happen in one
// clock edge, so no pair ever passes through 11.
// Assumes: tx_ack is synchronous to clk; tx_ack is low whenever idle.
module dr_tx
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic [WIDTH-1:0] rail_t,
    output logic [WIDTH-1:0] rail_f,
    input  logic             tx_ack
);

    tx_state_e state_q;

    // Ready only between transfers, after the previous ack has fallen.
    assign in_ready = (state_q == TX_IDLE) && !tx_ack;

    // Phase sequencer and rail registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            rail_t  <= '0;
            rail_f  <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (in_valid && in_ready) begin
                        rail_t  <= in_data;
                        rail_f  <= ~in_data;
                        state_q <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (tx_ack) begin
                        rail_t  <= '0;
                        rail_f  <= '0;
                        state_q <= TX_RTZ;
                    end
                end
                TX_RTZ: begin
                    if (!tx_ack) begin
                        state_q <= TX_IDLE;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Accepted word appears as a full codeword after the accept edge.
    assert_codeword_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((rail_t ^ rail_f) == {WIDTH{1'b1}}));

    // Codeword held steady while waiting for the acknowledge.
    assert_hold_codeword_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && !tx_ack) |=> ($stable(rail_t) && $stable(rail_f)));

    // Acknowledge seen high returns every pair to spacer.
    assert_spacer_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && tx_ack) |=> (rail_t == '0 && rail_f == '0));

    // No pair is ever driven to the illegal 11 code.
    assert_no_illegal_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t & rail_f) == '0);

endmodule

// File: rtl/dr_rx.sv
// Module: dr_rx
// Per-pair decode with completion, empty and illegal detection, and the
// acknowledge that closes each half of the handshake.
// Assumes: rail inputs are synchronous to clk.
module dr_rx #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             ack,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             proto_err
);

    logic [WIDTH-1:0] pair_valid;
    logic [WIDTH-1:0] pair_empty;
    logic [WIDTH-1:0] pair_bad;

    // One small classifier per bit pair.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        assign pair_valid[i] = rail_t[i] ^ rail_f[i];
        assign pair_empty[i] = ~(rail_t[i] | rail_f[i]);
        assign pair_bad[i]   = rail_t[i] & rail_f[i];
    end

    logic all_valid;
    logic all_empty;
    logic any_bad;

    assign all_valid = &pair_valid;
    assign all_empty = &pair_empty;
    assign any_bad   = |pair_bad;

    // Acknowledge, decoded word and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            proto_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            proto_err <= any_bad;
            if (!ack && all_valid) begin
                ack       <= 1'b1;
                out_valid <= 1'b1;
                out_data  <= rail_t;
            end else if (ack && all_empty) begin
                ack <= 1'b0;
            end
        end
    end

    // Ack rises only on a complete word.
    assert_ack_rise_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(all_valid));

    // Ack falls only after a full return to spacer.
    assert_ack_fall_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(all_empty));

    // An illegal pair is reported in the next cycle.
    assert_flag_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> proto_err);

    // Output word pulse coincides with the rising acknowledge.
    assert_valid_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ack && $rose(ack)));

endmodule

// File: rtl/dr_activity.sv
// Module: dr_activity
// Counts wire toggles on the observed dual-rail bus as an activity
// estimate. Saturates at all ones; synchronous clear wins over counting.
// Assumes: the wires are synchronous to clk; reset value of wires is 0.
module dr_activity #(
    parameter int WIRES = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIRES-1:0] wires,
    output logic [CNT_W-1:0] count
);

    localparam int DW = $clog2(WIRES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [WIRES-1:0] prev_q;
    logic [WIRES-1:0] diff;
    logic [DW-1:0]    delta;
    logic [CNT_W:0]   sum;

    assign diff = wires ^ prev_q;

    // Population count of the toggled wires.
    always_comb begin
        delta = '0;
        for (int i = 0; i < WIRES; i++) begin
            delta = delta + DW'(diff[i]);
        end
    end

    assign sum = {1'b0, count} + (CNT_W + 1)'(delta);

    // Previous-wire register and saturating accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            count  <= '0;
        end else begin
            prev_q <= wires;
            if (clr) begin
                count <= '0;
            end else if (sum[CNT_W]) begin
                count <= CNT_MAX;
            end else begin
                count <= sum[CNT_W-1:0];
            end
        end
    end

    // Saturated count never wraps.
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

    // Clear takes effect on the next edge.
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // Count is monotonic between clears.
    assert_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count >= $past(count)));

endmodule

// File: rtl/dr_channel_top.sv
// Module: dr_channel_top
// Sender and receiver of a dual-rail four-phase channel. The bus and the
// acknowledge leave on tx_* / rx_ack and come back on rx_* / tx_ack, so
// the surrounding level wires them and sets the return delay.
// Assumes: all pins synchronous to clk.
module dr_channel_top #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic [WIDTH-1:0] tx_t,
    output logic [WIDTH-1:0] tx_f,
    input  logic             tx_ack,
    input  logic [WIDTH-1:0] rx_t,
    input  logic [WIDTH-1:0] rx_f,
    output logic             rx_ack,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             proto_err,
    output logic [CNT_W-1:0] act_count
);

    localparam int WIRES = 2 * WIDTH;

    dr_tx #(.WIDTH(WIDTH)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .rail_t   (tx_t),
        .rail_f   (tx_f),
        .tx_ack   (tx_ack)
    );

    dr_rx #(.WIDTH(WIDTH)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_t    (rx_t),
        .rail_f    (rx_f),
        .ack       (rx_ack),
        .out_valid (out_valid),
        .out_data  (out_data),
        .proto_err (proto_err)
    );

    dr_activity #(.WIRES(WIRES), .CNT_W(CNT_W)) act_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .wires ({rx_t, rx_f}),
        .count (act_count)
    );

endmodule

// File: tb/dr_channel_top_tb_top.sv
`timescale 1ns/1ps
// Bench: loops the sender bus back to the receiver, delays the ack by a
// chosen number of cycles, sweeps every 4-bit word under eight delays.
module dr_channel_top_tb_top;

    localparam int W  = 4;
    localparam int CW = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          in_ready;
    logic [W-1:0]  tx_t, tx_f, rx_t, rx_f;
    logic [W-1:0]  inj_t = '0, inj_f = '0;
    logic          ack_line = 1'b0;
    logic          rx_ack, out_valid, proto_err;
    logic [W-1:0]  out_data;
    logic [CW-1:0] act_count;

    int checks = 0;
    int errors = 0;
    int ack_dly = 0;
    int dcnt = 0;
    int exp_cnt = 0;
    int illegal_tx = 0;

    always #2 clk = ~clk;

    assign rx_t = tx_t | inj_t;
    assign rx_f = tx_f | inj_f;

    dr_channel_top #(.WIDTH(W), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx_t(tx_t), .tx_f(tx_f), .tx_ack(ack_line),
        .rx_t(rx_t), .rx_f(rx_f), .rx_ack(rx_ack),
        .out_valid(out_valid), .out_data(out_data),
        .proto_err(proto_err), .act_count(act_count)
    );

    // Ack return path with a programmable delay in cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            ack_line = 1'b0;
            dcnt = 0;
        end else if (rx_ack != ack_line) begin
            if (dcnt >= ack_dly) begin
                ack_line = rx_ack;
                dcnt = 0;
            end else begin
                dcnt++;
            end
        end
        if ((tx_t & tx_f) != '0) illegal_tx++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full four-phase transfer; called and returns at a falling edge.
    task automatic xfer(input logic [W-1:0] w, input int d);
        int guard;
        ack_dly = d;
        in_data = w;
        in_valid = 1'b1;
        guard = 0;
        while (!in_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, "R4 out_valid", int'(out_valid), 1);
        chk(out_data == w, "R4 out_data", int'(out_data), int'(w));
        chk(rx_ack == 1'b1, "R4 rx_ack", int'(rx_ack), 1);
        chk(in_ready == 1'b0, "R2 busy", int'(in_ready), 0);
        guard = 0;
        while (!in_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        exp_cnt = (exp_cnt + 2 * W > CMAX) ? CMAX : exp_cnt + 2 * W;
        chk(rx_ack == 1'b0, "R5 ack low", int'(rx_ack), 0);
        chk(tx_t == '0 && tx_f == '0, "R3 spacer", int'({tx_t, tx_f}), 0);
        chk(int'(act_count) == exp_cnt, "R7 R8 count", int'(act_count), exp_cnt);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
        chk(tx_t == '0 && tx_f == '0, "R10 spacer", int'({tx_t, tx_f}), 0);
        chk(rx_ack == 0 && out_valid == 0 && proto_err == 0, "R10 flags",
            int'({rx_ack, out_valid, proto_err}), 0);
        chk(act_count == '0, "R10 count", int'(act_count), 0);

        // R6 illegal 11 pair on bit 0
        inj_t = 4'b0001; inj_f = 4'b0001;
        @(negedge clk);
        chk(proto_err == 1'b1, "R6 err set", int'(proto_err), 1);
        chk(rx_ack == 1'b0, "R6 no ack", int'(rx_ack), 0);
        chk(act_count == 2, "R7 two toggles", int'(act_count), 2);
        inj_t = '0; inj_f = '0;
        @(negedge clk);
        chk(proto_err == 1'b0, "R6 err clear", int'(proto_err), 0);
        chk(act_count == 4, "R7 four toggles", int'(act_count), 4);

        // R9 clear wins over a simultaneous toggle
        inj_t = 4'b0100; cnt_clr = 1'b1;
        @(negedge clk);
        chk(act_count == 0, "R9 clear priority", int'(act_count), 0);
        cnt_clr = 1'b0; inj_t = '0;
        @(negedge clk);
        chk(act_count == 1, "R7 single toggle", int'(act_count), 1);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        chk(act_count == 0, "R9 clear", int'(act_count), 0);
        exp_cnt = 0;

        // Sweep: every word under every ack delay 0..7; reaches saturation
        for (int d = 0; d < 8; d++) begin
            for (int v = 0; v < (1 << W); v++) begin
                xfer(W'(v), d);
            end
        end
        chk(act_count == CW'(CMAX), "R8 saturated", int'(act_count), CMAX);
        xfer(4'b1010, 2);
        chk(illegal_tx == 0, "R1 no 11 driven", illegal_tx, 0);

        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        exp_cnt = 0;
        xfer(4'b0110, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule